// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a small pipelined synchronous SRAM. Reads and writes can follow each other on back-to-back clock edges with no idle cycle between them. Every rising clock edge is decoded into one operation. The operation is a burst start with an external address, a burst continuation, a deselect, a stall or a sleep. A 2-bit burst counter steps through the low address bits. Read data and write data both travel through a two-stage pipeline. The storage is an internal register array with byte-lane writes.

The data bus is split into three signals: `dq_in`, `dq_out` and `dq_oe`. The host samples read data at the second enabled edge after the address edge. The host presents write data at that same point, two enabled edges after the address edge. Because of this, a read followed by a write never needs a turnaround cycle. The output enable and the sleep input act on the drivers without waiting for a clock edge.

Top module: `sram_nt`

## Requirements
- R1: The part is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A burst-start edge (`burst_next`=0) with the part not selected is a deselect. It performs no access, and one edge later `dq_oe` is 0.
- R2: A selected burst-start edge loads `addr` and begins a burst. With `wr_n`=1 the burst is a read. With `wr_n`=0 and at least one bit of `byte_en_n` low it is a write. With `wr_n`=0 and every `byte_en_n` bit high the edge is a deselect.
- R3: A continue edge (`burst_next`=1) inside a read or write burst increments address bits [1:0] with wrap-around (0,1,2,3,0). The upper bits stay fixed. The first continue accesses start+1. `wr_n` is ignored on continue edges, and the access keeps the type of its burst.
- R4: A continue edge inside a write burst with every `byte_en_n` bit high writes nothing. The burst address still advances.
- R5: Read data for an address edge drives `dq_out` from the next enabled edge on. The host samples it at the second enabled edge.
- R6: Write data is taken from `dq_in` at the second enabled edge after the address edge. Byte lane b (bits 8b+7:8b) is written only if `byte_en_n[b]` was 0 on the address edge. `dq_oe` stays 0 for a write slot.
- R7: A read always returns the latest data written by an earlier operation. This includes a write whose data is being stored on the very edge at which the read fetches.
- R8: `dq_oe` is 0 whenever `out_en_n` is 1, and this needs no clock edge. A read burst with `out_en_n` high still advances its address.
- R9: A continue edge that follows a deselect performs no access and keeps `dq_oe` at 0.
- R10: An edge with `stall`=1 is ignored and all state is held. A read being output keeps driving. A pending write stays undriven and uncommitted.
- R11: While `sleep`=1, `dq_oe` is 0 at once and clock edges are ignored with state held.
- R12: Reset (synchronous, active high) clears the pipeline, ends any burst and zeroes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | 1 = ignore this edge |
| burst_next | input | 1 | 0 = start burst, 1 = continue |
| wr_n | input | 1 | 0 = write, 1 = read (burst start only) |
| byte_en_n | input | BYTES | Active-low byte lane enables |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench goes after bursts that wrap the low address bits. A counter that carried into the upper bits, or that started at the start address on the first continue, would return data from the wrong word. It pairs a write with a read of the same word on the next edge. Without forwarding, that read would return stale data. It drops every byte enable in the middle of a write burst, expecting the array untouched and the counter still moving. It places stalls and sleeps inside read and write bursts, where a design that lost or duplicated a pipeline slot would shift every later result by one edge. It also places deselects before continue edges, where a design that kept the old burst type would perform spurious accesses.

// File: rtl/sram_nt_pkg.sv
package sram_nt_pkg;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_READ  = 2'd1,
        BK_WRITE = 2'd2
    } burst_kind_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_t;

    localparam int BURST_BITS = 2;

    function automatic logic [BURST_BITS-1:0] wrap_step(input logic [BURST_BITS-1:0] v);
        return v + 1'b1;
    endfunction

endpackage

// File: rtl/sram_nt_dec.sv
module sram_nt_dec
    import sram_nt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              burst_next,
    input  logic              wr_n,
    input  logic [BYTES-1:0]  byte_en_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic [ADDR_W-1:0] addr,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTES-1:0]  op_be,
    output burst_kind_t       b_kind,
    output logic [1:0]        burst_lo
);
    logic [ADDR_W-1:0] b_addr;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] nxt_addr;
    burst_kind_t       nxt_kind;
    logic              selected;
    logic              any_be;

    assign selected = !cs0_n && cs1 && !cs2_n;
    assign any_be   = |(~byte_en_n);
    assign burst_lo = b_addr[1:0];

    always_comb begin
        step_addr      = b_addr;
        step_addr[1:0] = wrap_step(b_addr[1:0]);
    end

    always_comb begin
        nxt_kind = b_kind;
        nxt_addr = b_addr;
        op_kind  = OP_NONE;
        op_addr  = b_addr;
        op_be    = ~byte_en_n;
        if (!burst_next) begin
            if (selected && wr_n) begin
                op_kind  = OP_READ;
                op_addr  = addr;
                nxt_kind = BK_READ;
                nxt_addr = addr;
            end else if (selected && any_be) begin
                op_kind  = OP_WRITE;
                op_addr  = addr;
                nxt_kind = BK_WRITE;
                nxt_addr = addr;
            end else begin
                nxt_kind = BK_IDLE;
            end
        end else begin
            unique case (b_kind)
                BK_READ: begin
                    op_kind  = OP_READ;
                    op_addr  = step_addr;
                    nxt_addr = step_addr;
                end
                BK_WRITE: begin
                    op_kind  = any_be ? OP_WRITE : OP_NONE;
                    op_addr  = step_addr;
                    nxt_addr = step_addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_kind <= BK_IDLE;
            b_addr <= '0;
        end else if (en) begin
            b_kind <= nxt_kind;
            b_addr <= nxt_addr;
        end
    end

endmodule

// File: rtl/sram_nt_pipe.sv
module sram_nt_pipe
    import sram_nt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  op_kind_t          op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [BYTES-1:0]  op_be,
    output op_kind_t          s1_kind,
    output logic [ADDR_W-1:0] s1_addr,
    output op_kind_t          s2_kind,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [BYTES-1:0]  s2_be
);
    logic [BYTES-1:0] s1_be;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind <= OP_NONE;
            s1_addr <= '0;
            s1_be   <= '0;
            s2_kind <= OP_NONE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (en) begin
            s1_kind <= op_kind;
            s1_addr <= op_addr;
            s1_be   <= op_be;
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

endmodule

// File: rtl/sram_nt_store.sv
module sram_nt_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] fwd;
    logic              hit;

    assign hit = wr && (wr_addr == rd_addr);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign fwd[g*BYTE_W +: BYTE_W] = (hit && wr_be[g]) ? wdata[g*BYTE_W +: BYTE_W]
                                                           : mem[rd_addr][g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (en && wr) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (en) begin
            rvalid <= rd;
            if (rd) rdata <= fwd;
        end
    end

endmodule

// File: rtl/sram_nt.sv
module sram_nt
    import sram_nt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              burst_next,
    input  logic              wr_n,
    input  logic [BYTES-1:0]  byte_en_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              en;
    op_kind_t          op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [BYTES-1:0]  op_be;
    burst_kind_t       b_kind;
    logic [1:0]        burst_lo;
    op_kind_t          s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    op_kind_t          s2_kind;
    logic [ADDR_W-1:0] s2_addr;
    logic [BYTES-1:0]  s2_be;
    logic              rvalid;

    assign en = !stall && !sleep;

    sram_nt_dec #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_dec (
        .clk(clk), .rst(rst), .en(en),
        .burst_next(burst_next), .wr_n(wr_n), .byte_en_n(byte_en_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .addr(addr),
        .op_kind(op_kind), .op_addr(op_addr), .op_be(op_be),
        .b_kind(b_kind), .burst_lo(burst_lo)
    );

    sram_nt_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
        .clk(clk), .rst(rst), .en(en),
        .op_kind(op_kind), .op_addr(op_addr), .op_be(op_be),
        .s1_kind(s1_kind), .s1_addr(s1_addr),
        .s2_kind(s2_kind), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    sram_nt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst(rst), .en(en),
        .wr(s2_kind == OP_WRITE), .wr_addr(s2_addr), .wr_be(s2_be), .wdata(dq_in),
        .rd(s1_kind == OP_READ), .rd_addr(s1_addr),
        .rdata(dq_out), .rvalid(rvalid)
    );

    assign dq_oe = rvalid && !out_en_n && !sleep;

endmodule

// File: rtl/sram_nt_chk.sv
module sram_nt_chk
    import sram_nt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        sleep,
    input logic        out_en_n,
    input logic        burst_next,
    input logic        cs0_n,
    input logic        cs1,
    input logic        cs2_n,
    input logic        dq_oe,
    input logic [15:0] dq_out,
    input op_kind_t    s1_kind,
    input burst_kind_t b_kind,
    input logic [1:0]  burst_lo
);
    logic edge_on;
    assign edge_on = !stall && !sleep;

    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dq_oe);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (stall && !sleep) |=> ($stable(dq_out) && $stable(s1_kind)));

    assert_desel_R1: assert property (@(posedge clk) disable iff (rst)
        (edge_on && !burst_next && !(!cs0_n && cs1 && !cs2_n)) |=> (s1_kind == OP_NONE));

    assert_burst_step_R3: assert property (@(posedge clk) disable iff (rst)
        (edge_on && burst_next && b_kind != BK_IDLE) |=> (burst_lo == $past(burst_lo) + 2'd1));

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_on && s1_kind == OP_WRITE) |=> !dq_oe);

endmodule

bind sram_nt sram_nt_chk u_chk (
    .clk(clk), .rst(rst), .stall(stall), .sleep(sleep), .out_en_n(out_en_n),
    .burst_next(burst_next), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .s1_kind(s1_kind), .b_kind(b_kind),
    .burst_lo(burst_lo)
);

// File: tb/sim_sram_nt.sv
`timescale 1ns/1ps
module sim_sram_nt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        burst_next = 1'b0;
    logic        wr_n = 1'b1;
    logic [1:0]  byte_en_n = 2'b11;
    logic        cs0_n = 1'b1;
    logic        cs1 = 1'b0;
    logic        cs2_n = 1'b1;
    logic        out_en_n = 1'b0;
    logic        sleep = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R12";

    // reference model state
    logic [15:0] ref_mem [64];
    int          q_kind [2];
    int          q_addr [2];
    logic [1:0]  q_be [2];
    int          mb_kind;
    int          mb_addr;
    bit          m_valid;
    logic [15:0] m_data;

    always #5 clk = ~clk;

    sram_nt u0 (
        .clk(clk), .rst(rst), .stall(stall), .burst_next(burst_next), .wr_n(wr_n),
        .byte_en_n(byte_en_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .out_en_n(out_en_n), .sleep(sleep), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) ref_mem[i] = '0;
            q_kind[0] = 0; q_kind[1] = 0;
            mb_kind = 0; mb_addr = 0;
            m_valid = 0; m_data = '0;
        end else if (!stall && !sleep) begin
            bit sel;
            bit anybe;
            if (q_kind[0] == 2) begin
                if (!q_be[0][0]) ref_mem[q_addr[0]][7:0]  = dq_in[7:0];
                if (!q_be[0][1]) ref_mem[q_addr[0]][15:8] = dq_in[15:8];
            end
            m_valid = (q_kind[1] == 1);
            if (m_valid) m_data = ref_mem[q_addr[1]];
            q_kind[0] = q_kind[1]; q_addr[0] = q_addr[1]; q_be[0] = q_be[1];
            sel   = !cs0_n && cs1 && !cs2_n;
            anybe = (byte_en_n != 2'b11);
            q_kind[1] = 0; q_be[1] = byte_en_n;
            if (!burst_next) begin
                if (sel && wr_n) begin
                    mb_kind = 1; mb_addr = addr; q_kind[1] = 1; q_addr[1] = addr;
                end else if (sel && anybe) begin
                    mb_kind = 2; mb_addr = addr; q_kind[1] = 2; q_addr[1] = addr;
                end else begin
                    mb_kind = 0;
                end
            end else if (mb_kind != 0) begin
                mb_addr = (mb_addr & ~3) | ((mb_addr + 1) & 3);
                q_addr[1] = mb_addr;
                if (mb_kind == 1) q_kind[1] = 1;
                else q_kind[1] = anybe ? 2 : 0;
            end
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected at most 100000", cycles);
            summary_and_end();
        end
    end

    task automatic tick();
        bit eo;
        dq_in = 16'($urandom);
        @(negedge clk);
        eo = m_valid && !out_en_n && !sleep;
        checks++;
        if (dq_oe !== eo) begin
            errors++;
            $display("FAIL %s: dq_oe=%0b expected %0b at %0t", cur_req, dq_oe, eo, $time);
        end
        if (eo) begin
            checks++;
            if (dq_out !== m_data) begin
                errors++;
                $display("FAIL %s: dq_out=%h expected %h at %0t", cur_req, dq_out, m_data, $time);
            end
        end
    endtask

    // cs: 0 = selected, 1/2/3 = that chip select inactive
    task automatic set_cs(input int cs);
        cs0_n = (cs == 1); cs1 = (cs != 2); cs2_n = (cs == 3);
    endtask

    task automatic start_rd(input int a);
        set_cs(0); burst_next = 0; wr_n = 1; addr = 6'(a); tick();
    endtask

    task automatic start_wr(input int a, input logic [1:0] ben);
        set_cs(0); burst_next = 0; wr_n = 0; byte_en_n = ben; addr = 6'(a); tick();
    endtask

    task automatic cont(input logic [1:0] ben);
        burst_next = 1; byte_en_n = ben; wr_n = 1'($urandom); set_cs(int'($urandom % 4)); tick();
    endtask

    task automatic desel(input int cs);
        set_cs(cs); burst_next = 0; wr_n = 1; tick();
    endtask

    initial begin
        // R12: reset state and zeroed array
        cur_req = "R12";
        rst = 1;
        tick(); tick(); tick();
        rst = 0;
        tick();
        start_rd(5); desel(1); desel(1);

        // R2 / R6: full and partial writes, reads back
        cur_req = "R2";
        start_wr(8, 2'b00); start_wr(9, 2'b00); desel(2); desel(2);
        cur_req = "R6";
        start_wr(9, 2'b10); start_wr(8, 2'b01); desel(3); desel(3);
        start_rd(8); start_rd(9); desel(1); desel(1);
        cur_req = "R2";
        start_wr(10, 2'b11); desel(1); desel(1); start_rd(10); desel(1); desel(1);

        // R3: wrapping bursts, wr_n ignored on continue
        cur_req = "R3";
        start_wr(14, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00); desel(1); desel(1);
        start_rd(12); cont(2'b11); cont(2'b11); cont(2'b11); cont(2'b11); desel(1); desel(1);
        start_rd(15); cont(2'b00); desel(2); desel(2);

        // R4: write abort mid burst
        cur_req = "R4";
        start_wr(20, 2'b00); cont(2'b11); cont(2'b00); desel(1); desel(1);
        start_rd(20); cont(2'b11); cont(2'b11); desel(1); desel(1);

        // R7: read right behind a write of the same word
        cur_req = "R7";
        start_wr(30, 2'b00); start_rd(30); desel(1); desel(1);
        start_wr(31, 2'b01); start_rd(31); start_wr(31, 2'b10); start_rd(31); desel(1); desel(1);

        // R8: dummy reads
        cur_req = "R8";
        start_rd(8); out_en_n = 1; cont(2'b11); cont(2'b11); out_en_n = 0; cont(2'b11); desel(1);
        out_en_n = 1; tick(); out_en_n = 0; tick();

        // R9: continue after deselect
        cur_req = "R9";
        desel(3); cont(2'b00); cont(2'b00); cont(2'b00); desel(1); desel(1);

        // R1: each select inactive on a burst start
        cur_req = "R1";
        for (int c = 1; c < 4; c++) begin
            set_cs(c); burst_next = 0; wr_n = 1; addr = 6'(8); tick(); tick();
        end
        desel(1);

        // R10: stalls in read and write bursts
        cur_req = "R10";
        start_rd(12); cont(2'b11); stall = 1; tick(); tick(); stall = 0; cont(2'b11); desel(1); desel(1);
        start_wr(40, 2'b00); stall = 1; tick(); stall = 0; cont(2'b00); stall = 1; tick(); tick();
        stall = 0; desel(1); desel(1); start_rd(40); cont(2'b11); desel(1); desel(1);

        // R11: sleep during bursts
        cur_req = "R11";
        start_rd(40); cont(2'b11); sleep = 1; tick(); tick(); sleep = 0; cont(2'b11); desel(1);
        start_wr(44, 2'b00); sleep = 1; tick(); sleep = 0; cont(2'b00); desel(1); desel(1);
        start_rd(44); cont(2'b11); desel(1); desel(1);

        // R5: random mix
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            set_cs(r < 13 ? 0 : r - 12);
            burst_next = ($urandom % 3) != 0;
            wr_n       = 1'($urandom);
            byte_en_n  = 2'($urandom);
            addr       = 6'($urandom);
            stall      = ($urandom % 10) == 0;
            sleep      = ($urandom % 20) == 0;
            out_en_n   = ($urandom % 7) == 0;
            tick();
        end
        stall = 0; sleep = 0; out_en_n = 0;
        desel(1); desel(1);
        summary_and_end();
    end

endmodule